// File: doc/BRIEF.md
# Edge-Detecting General-Purpose I/O Controller

A 28-pin general-purpose I/O block on a simple register bus. Each pin can be set as an input or an output. Output levels live in an output latch. Software changes that latch only through two write-only registers: one sets bits and the other clears them, so one pin can change without a read-modify-write. Input pins pass through a two-flop synchronizer. Edges are then judged on the synchronized levels against per-pin rising and falling enables. A detected edge is held in a sticky status register until software writes a one to that bit.

Interrupts leave the block as eleven dedicated lines that follow status bits 0 to 10, plus one shared line for any pending status among pins 11 to 27. An alternate-function register is stored and read back but drives nothing; pin multiplexing is done elsewhere.

The bus is a single-cycle strobe (`req_i`, `we_i`) with a byte address. A write takes effect at the clock edge on which it is presented. Read data is combinational from the current state.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every register reads zero, `pin_o`, `pin_oe_o`, `irq_low_o` and `irq_high_o` are zero.
- R2: The direction register at offset 0x04 keeps bits [27:0] and reads bits [31:28] as zero. A 1 makes the pin an output, and `pin_oe_o` equals the stored direction.
- R3: A write to offset 0x08 ORs bits [27:0] of the data into the output latch, and a write to offset 0x0C clears the latch bits written as one. Both offsets read as zero. `pin_o` is the latch ANDed with the direction.
- R4: A read of offset 0x00 returns the latch bit for output pins and the synchronized input for input pins. A change on `pin_i` becomes visible in this read after the second rising clock edge.
- R5: The rising-enable register (0x10) and falling-enable register (0x14) keep bits [27:0] and read bits [31:28] as zero. The alternate-function register (0x1C) stores all 32 bits and does not affect any pin or interrupt.
- R6: On an input pin, a synchronized low-to-high change with its rising enable set, or high-to-low with its falling enable set, sets that pin's bit in the status register (0x18). The bit shows after the third rising clock edge following the `pin_i` change and stays set.
- R7: No status bit is set for a pin whose direction bit is 1, or for an edge whose enable is off.
- R8: Writing one to a status bit clears it, and writing zero leaves it. If an edge is detected on the same clock edge as the clearing write, the bit stays set.
- R9: `irq_low_o[i]` follows status bit i for i from 0 to 10. `irq_high_o` is high exactly when any status bit from 11 to 27 is set.
- R10: Offsets other than the eight listed (including misaligned ones) read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| pin_i | input | 28 | Pin input levels, asynchronous |
| pin_o | output | 28 | Output levels (latch AND direction) |
| pin_oe_o | output | 28 | Output enables (direction) |
| irq_low_o | output | 11 | Per-pin interrupt lines for pins 0 to 10 |
| irq_high_o | output | 1 | Shared interrupt for pins 11 to 27 |

## Verification
Register writes take effect at the clock edge on which they are presented, and the readback is due half a cycle later. Input changes are staggered. The level read changes after the second clock edge and the status bit and interrupt lines change after the third, so the bench steps one edge at a time. At each step it samples both the not-yet value and the due value. All samples are taken one nanosecond after a falling edge, away from the active edge. The clear/edge collision is set up by presenting the clearing write in exactly the cycle in which the synchronized edge is seen.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFF_LEVEL  = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_DIR    = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_SET    = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_CLR    = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_RISE   = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_FALL   = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_ALT    = 6'h1C;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 28,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int NUM_PINS = 28
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] sync_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] rise_en_i,
  input  logic [NUM_PINS-1:0] fall_en_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] status_o
);
  logic [NUM_PINS-1:0] prev_q, status_q, det;

  always_comb begin
    det = ((sync_i & ~prev_q & rise_en_i) | (~sync_i & prev_q & fall_en_i)) & ~dir_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= sync_i;
      // new edge wins over a clearing write in the same cycle
      status_q <= (status_q & ~clr_i) | det;
    end
  end

  assign status_o = status_q;

  // R7
  out_no_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & $past(dir_i)) == '0));

  // R6
  sticky_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(status_q) & ~$past(clr_i)) & ~status_q) == '0));

  // R8
  clear_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(clr_i) & ~$past(det)) == '0));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 28,
  parameter int DATA_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] sync_i,
  input  logic [NUM_PINS-1:0] status_i,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] latch_o,
  output logic [NUM_PINS-1:0] rise_en_o,
  output logic [NUM_PINS-1:0] fall_en_o,
  output logic [NUM_PINS-1:0] stat_clr_o
);
  localparam int PAD_W = DATA_W - NUM_PINS;

  logic [NUM_PINS-1:0] dir_q, latch_q, rise_q, fall_q;
  logic [DATA_W-1:0]   alt_q;
  logic [NUM_PINS-1:0] wpins;
  logic                wr, rd;

  assign wr    = req_i & we_i;
  assign rd    = req_i & ~we_i;
  assign wpins = wdata_i[NUM_PINS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      latch_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      alt_q   <= '0;
    end else if (wr) begin
      case (addr_i)
        OFF_DIR:  dir_q   <= wpins;
        OFF_SET:  latch_q <= latch_q | wpins;
        OFF_CLR:  latch_q <= latch_q & ~wpins;
        OFF_RISE: rise_q  <= wpins;
        OFF_FALL: fall_q  <= wpins;
        OFF_ALT:  alt_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  assign stat_clr_o = (wr && addr_i == OFF_STATUS) ? wpins : '0;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (addr_i)
        OFF_LEVEL:  rdata_o = {{PAD_W{1'b0}}, (latch_q & dir_q) | (sync_i & ~dir_q)};
        OFF_DIR:    rdata_o = {{PAD_W{1'b0}}, dir_q};
        OFF_RISE:   rdata_o = {{PAD_W{1'b0}}, rise_q};
        OFF_FALL:   rdata_o = {{PAD_W{1'b0}}, fall_q};
        OFF_STATUS: rdata_o = {{PAD_W{1'b0}}, status_i};
        OFF_ALT:    rdata_o = alt_q;
        default:    rdata_o = '0;
      endcase
    end
  end

  assign dir_o     = dir_q;
  assign latch_o   = latch_q;
  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;

  // R3
  set_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFF_SET) |=> ((latch_q & $past(wpins)) == $past(wpins)));

  // R3
  clr_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFF_CLR) |=> ((latch_q & $past(wpins)) == '0));

  // R10
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i[1:0] != 2'b00) |-> (rdata_o == '0));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS       = 28,
  parameter int NUM_DIRECT_IRQ = 11,
  parameter int DATA_W         = 32,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  input  logic [NUM_PINS-1:0]       pin_i,
  output logic [NUM_PINS-1:0]       pin_o,
  output logic [NUM_PINS-1:0]       pin_oe_o,
  output logic [NUM_DIRECT_IRQ-1:0] irq_low_o,
  output logic                      irq_high_o
);
  logic [NUM_PINS-1:0] sync, status, dir, latch, rise_en, fall_en, stat_clr;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(sync)
  );

  gpio_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) i_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .sync_i(sync), .status_i(status), .dir_o(dir), .latch_o(latch),
    .rise_en_o(rise_en), .fall_en_o(fall_en), .stat_clr_o(stat_clr)
  );

  gpio_edge_det #(.NUM_PINS(NUM_PINS)) i_edge (
    .clk_i, .rst_ni, .sync_i(sync), .dir_i(dir), .rise_en_i(rise_en),
    .fall_en_i(fall_en), .clr_i(stat_clr), .status_o(status)
  );

  assign pin_o      = latch & dir;
  assign pin_oe_o   = dir;
  assign irq_low_o  = status[NUM_DIRECT_IRQ-1:0];
  assign irq_high_o = |status[NUM_PINS-1:NUM_DIRECT_IRQ];

  // R9
  high_irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_high_o) |-> $past(|stat_clr[NUM_PINS-1:NUM_DIRECT_IRQ]));

  // R9
  low_irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(irq_low_o) & ~irq_low_o & ~$past(stat_clr[NUM_DIRECT_IRQ-1:0])) == '0));
endmodule

// File: tb/test_gpio_edge_ctrl.sv
module test_gpio_edge_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [27:0] pin_i = '0, pin_o, pin_oe_o;
  logic [10:0] irq_low_o;
  logic        irq_high_o;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  gpio_edge_ctrl i_gpio_edge_ctrl (.*);

  typedef struct packed {
    logic        wr;
    logic [5:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'h04, 32'hFFFF_FFFF, 32'h0},          // R2
    '{1'b0, 6'h04, 32'h0,         32'h0FFF_FFFF},  // R2
    '{1'b1, 6'h04, 32'h0000_00F0, 32'h0},
    '{1'b0, 6'h04, 32'h0,         32'h0000_00F0},  // R2
    '{1'b1, 6'h08, 32'hFFFF_FFFF, 32'h0},          // R3
    '{1'b0, 6'h08, 32'h0,         32'h0},          // R3
    '{1'b0, 6'h0C, 32'h0,         32'h0},          // R3
    '{1'b0, 6'h00, 32'h0,         32'h0000_00F0},  // R4
    '{1'b1, 6'h0C, 32'h0000_0030, 32'h0},          // R3
    '{1'b0, 6'h00, 32'h0,         32'h0000_00C0},  // R4
    '{1'b1, 6'h10, 32'hFFFF_FFFF, 32'h0},          // R5
    '{1'b0, 6'h10, 32'h0,         32'h0FFF_FFFF},  // R5
    '{1'b1, 6'h14, 32'h1234_5678, 32'h0},
    '{1'b0, 6'h14, 32'h0,         32'h0234_5678},  // R5
    '{1'b1, 6'h1C, 32'hDEAD_BEEF, 32'h0},
    '{1'b0, 6'h1C, 32'h0,         32'hDEAD_BEEF},  // R5
    '{1'b1, 6'h04, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 6'h00, 32'h0,         32'h0FFF_FFCF},  // R4
    '{1'b1, 6'h24, 32'hFFFF_FFFF, 32'h0},          // R10
    '{1'b0, 6'h24, 32'h0,         32'h0},          // R10
    '{1'b0, 6'h06, 32'h0,         32'h0}           // R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic peek(input logic [5:0] a, output logic [31:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    req_i = 1'b0;
  endtask

  initial begin
    logic [31:0] r;
    #20 rst_ni = 1'b1;
    step();

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      peek(6'(a * 4), r);
      check("R1 reg", r, 32'h0);
    end
    check("R1 pin_o", {4'h0, pin_o}, 32'h0);
    check("R1 pin_oe_o", {4'h0, pin_oe_o}, 32'h0);
    check("R1 irq", {20'h0, irq_high_o, irq_low_o}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
      else begin
        peek(VECS[i].addr, r);
        check($sformatf("R2-5/R10 vec %0d", i), r, VECS[i].exp);
      end
    end
    peek(6'h04, r);
    check("R10 dir kept", r, 32'h0FFF_FFFF);
    check("R3 pin_o", {4'h0, pin_o}, 32'h0FFF_FFCF);
    check("R2 pin_oe_o", {4'h0, pin_oe_o}, 32'h0FFF_FFFF);
    check("R5 alt no irq", {20'h0, irq_high_o, irq_low_o}, 32'h0);

    // rising edges on pins 3 and 20
    wr(6'h04, 32'h0);
    wr(6'h14, 32'h0);
    pin_i = 28'h010_0008;
    step();
    peek(6'h00, r); check("R4 level not yet", r, 32'h0);
    step();
    peek(6'h00, r); check("R4 level after 2 edges", r, 32'h0010_0008);
    peek(6'h18, r); check("R6 status not yet", r, 32'h0);
    step();
    peek(6'h18, r); check("R6 rising status", r, 32'h0010_0008);
    check("R9 irq_low", {21'h0, irq_low_o}, 32'h8);
    check("R9 irq_high", {31'h0, irq_high_o}, 32'h1);

    // falling edge with falling enable off
    pin_i = '0;
    repeat (4) step();
    peek(6'h18, r); check("R7 fall disabled", r, 32'h0010_0008);

    // clear by writing one
    wr(6'h18, 32'h0000_0008);
    peek(6'h18, r); check("R8 clear bit 3", r, 32'h0010_0000);
    check("R9 irq_low cleared", {21'h0, irq_low_o}, 32'h0);
    check("R9 irq_high held", {31'h0, irq_high_o}, 32'h1);
    wr(6'h18, 32'h0010_0000);
    check("R9 irq_high cleared", {31'h0, irq_high_o}, 32'h0);

    // output pin: no status, level shows latch
    wr(6'h04, 32'h0000_0020);
    pin_i = 28'h000_0020;
    repeat (4) step();
    peek(6'h18, r); check("R7 output pin", r, 32'h0);
    peek(6'h00, r); check("R4 output level", r, 32'h0);

    // falling edge with enable
    wr(6'h04, 32'h0);
    wr(6'h14, 32'h0000_0020);
    pin_i = '0;
    repeat (3) step();
    peek(6'h18, r); check("R6 falling status", r, 32'h0000_0020);
    check("R9 irq_low bit5", {21'h0, irq_low_o}, 32'h20);

    // clear collides with new edge
    pin_i = 28'h000_0020;
    step();
    step();
    req_i = 1'b1; we_i = 1'b1; addr_i = 6'h18; wdata_i = 32'h20;
    step();
    req_i = 1'b0; we_i = 1'b0;
    peek(6'h18, r); check("R8 edge beats clear", r, 32'h0000_0020);
    wr(6'h18, 32'h0000_0020);
    peek(6'h18, r); check("R8 clear after", r, 32'h0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule